// File: doc/BRIEF.md
# Four-Bit Bidirectional Shift Register with Parallel Load

This block is a small register of four flip-flops whose next value on every rising clock edge is set by a two-bit mode input. It can keep its contents, move them one place towards either end, or take a whole new word from a parallel input. A serial input sits at each end to feed the shifts, and a serial output is taken from each end bit. Software-free datapaths use it to turn a parallel word into a bit stream (load, then shift) or to gather a bit stream into a word (shift, then read the parallel output).

Each bit is a cell made of a small selector and one flip-flop. The selector chooses between the cell's own value, its left or right neighbour, its parallel input bit, or zero. A shared decoder turns the mode and a clear request into one command that all cells obey. In this description bit 3 is the leftmost bit and bit 0 is the rightmost.

Top module: `ushift_reg`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the register becomes 0000 at that edge, whatever `clr` and `mode` are.
- R2: With `rst_n` high and `clr` high at a rising edge, the register becomes 0000 at that edge for every value of `mode`.
- R3: With `mode` = 2'b00 (and `clr` low), the register keeps its value at the edge, and changes on the data inputs between edges do not alter `par_out`.
- R4: With `mode` = 2'b10 (right shift), each bit i below 3 takes the old bit i+1, and bit 3 takes `ser_from_left`.
- R5: With `mode` = 2'b01 (left shift), each bit i above 0 takes the old bit i-1, and bit 0 takes `ser_from_right`.
- R6: With `mode` = 2'b11 (load), all four bits take `par_in` at the edge.
- R7: `par_out` shows all four register bits, `ser_out_left` always equals bit 3 and `ser_out_right` always equals bit 0, with no extra register stage.
- R8: After a load of word W, four right shifts present W on `ser_out_right` least significant bit first, and four left shifts present W on `ser_out_left` most significant bit first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear, active high, overrides `mode` |
| mode | input | 2 | 00 hold, 10 shift right, 01 shift left, 11 load |
| ser_from_left | input | 1 | Bit entering bit 3 on a right shift |
| ser_from_right | input | 1 | Bit entering bit 0 on a left shift |
| par_in | input | 4 | Word taken on a load |
| par_out | output | 4 | Current register contents |
| ser_out_left | output | 1 | Leftmost register bit (bit 3) |
| ser_out_right | output | 1 | Rightmost register bit (bit 0) |

## Verification
Every mode, clear and reset takes effect at the first rising edge at which it is presented, so each register result is due exactly one edge after its inputs are set up, while the serial outputs follow the register with no delay of their own. The bench sets inputs on the falling edge, lets one rising edge pass, and samples one nanosecond after that edge, before the next inputs are applied. For the hold case it also samples again just before the following edge, after stirring the data inputs, to show that nothing moves between edges. The serialisation test reads the end bit before each shift, so it collects the stream in the order in which it leaves the register.

// File: rtl/ushift_pkg.sv
// Package: shared types of the bidirectional shift register.
// Assumes: mode encoding is fixed and visible at the top-level port.
package ushift_pkg;

    // Mode values as seen on the top-level port.
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'b00,
        MODE_SHL   = 2'b01,
        MODE_SHR   = 2'b10,
        MODE_LOAD  = 2'b11
    } mode_e;

    // Decoded command that every bit cell obeys.
    typedef enum logic [2:0] {
        CELL_KEEP  = 3'd0,
        CELL_LEFT  = 3'd1,
        CELL_RIGHT = 3'd2,
        CELL_PAR   = 3'd3,
        CELL_ZERO  = 3'd4
    } cell_cmd_e;

endpackage

// File: rtl/ushift_ctrl.sv
// Module: ushift_ctrl
// Turns the mode pair and the clear request into one cell command.
// Assumes: clear wins over every mode; purely combinational.
module ushift_ctrl
    import ushift_pkg::*;
(
    input  logic       clr,
    input  logic [1:0] mode,
    output cell_cmd_e  cmd
);

    // Map clear and mode to the command shared by all cells.
    always_comb begin
        if (clr) begin
            cmd = CELL_ZERO;
        end else begin
            unique case (mode_e'(mode))
                MODE_HOLD: cmd = CELL_KEEP;
                MODE_SHR:  cmd = CELL_LEFT;
                MODE_SHL:  cmd = CELL_RIGHT;
                MODE_LOAD: cmd = CELL_PAR;
                default:   cmd = CELL_KEEP;
            endcase
        end
    end

endmodule

// File: rtl/ushift_cell.sv
// Module: ushift_cell
// One register bit: a selector in front of a single flip-flop.
// Assumes: neighbour values come from the cells (or serial inputs)
// beside it; reset is synchronous and active low.
module ushift_cell
    import ushift_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  cell_cmd_e cmd,
    input  logic      left_nbr,
    input  logic      right_nbr,
    input  logic      par_bit,
    output logic      q
);

    logic d_next;

    // Pick the next value of this bit from the decoded command.
    always_comb begin
        unique case (cmd)
            CELL_KEEP:  d_next = q;
            CELL_LEFT:  d_next = left_nbr;
            CELL_RIGHT: d_next = right_nbr;
            CELL_PAR:   d_next = par_bit;
            CELL_ZERO:  d_next = 1'b0;
            default:    d_next = q;
        endcase
    end

    // Store the selected value on the rising edge; reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            q <= d_next;
        end
    end

endmodule

// File: rtl/ushift_reg.sv
// Module: ushift_reg (top)
// Bidirectional shift register with parallel load, hold and clear.
// Bit WIDTH-1 is the left end, bit 0 the right end.
// Assumes: all inputs are synchronous to clk.
module ushift_reg
    import ushift_pkg::*;
#(
    parameter int WIDTH = 4
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [1:0]       mode,
    input  logic             ser_from_left,
    input  logic             ser_from_right,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] par_out,
    output logic             ser_out_left,
    output logic             ser_out_right
);

    localparam int EXT_W = WIDTH + 2;

    cell_cmd_e        cmd;
    logic [WIDTH-1:0] q_bits;
    logic [EXT_W-1:0] chain;

    ushift_ctrl u_ctrl (
        .clr  (clr),
        .mode (mode),
        .cmd  (cmd)
    );

    // Register bits framed by the two serial inputs.
    assign chain = {ser_from_left, q_bits, ser_from_right};

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        ushift_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd       (cmd),
            .left_nbr  (chain[i+2]),
            .right_nbr (chain[i]),
            .par_bit   (par_in[i]),
            .q         (q_bits[i])
        );
    end

    // Outputs come straight from the flip-flops.
    assign par_out       = q_bits;
    assign ser_out_left  = q_bits[WIDTH-1];
    assign ser_out_right = q_bits[0];

endmodule

// File: rtl/ushift_reg_chk.sv
// Module: ushift_reg_chk
// Checker bound to ushift_reg; observes ports only.
module ushift_reg_chk #(
    parameter int WIDTH = 4
)(
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic [1:0]       mode,
    input logic             ser_from_left,
    input logic             ser_from_right,
    input logic [WIDTH-1:0] par_in,
    input logic [WIDTH-1:0] par_out,
    input logic             ser_out_left,
    input logic             ser_out_right
);

    a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (par_out == '0));

    a_r3_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && mode == 2'b00) |=> $stable(par_out));

    a_r4_shift_right: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && mode == 2'b10) |=>
        (par_out == {$past(ser_from_left), $past(par_out[WIDTH-1:1])}));

    a_r5_shift_left: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && mode == 2'b01) |=>
        (par_out == {$past(par_out[WIDTH-2:0]), $past(ser_from_right)}));

    a_r6_load_word: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && mode == 2'b11) |=> (par_out == $past(par_in)));

    a_r7_end_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_out_left == par_out[WIDTH-1]) && (ser_out_right == par_out[0]));

endmodule

bind ushift_reg ushift_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .clr            (clr),
    .mode           (mode),
    .ser_from_left  (ser_from_left),
    .ser_from_right (ser_from_right),
    .par_in         (par_in),
    .par_out        (par_out),
    .ser_out_left   (ser_out_left),
    .ser_out_right  (ser_out_right)
);

// File: tb/ushift_reg_test.sv
module ushift_reg_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       ser_from_left = 1'b0;
    logic       ser_from_right = 1'b0;
    logic [3:0] par_in = 4'h0;
    logic [3:0] par_out;
    logic       ser_out_left;
    logic       ser_out_right;

    int checks = 0;
    int errors = 0;

    ushift_reg #(.WIDTH(4)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .clr            (clr),
        .mode           (mode),
        .ser_from_left  (ser_from_left),
        .ser_from_right (ser_from_right),
        .par_in         (par_in),
        .par_out        (par_out),
        .ser_out_left   (ser_out_left),
        .ser_out_right  (ser_out_right)
    );

    always #5 clk = ~clk;

    // Vector: {clr, mode[1:0], ser_from_left, ser_from_right, par_in[3:0], expected[3:0]}
    localparam int NVEC = 14;
    localparam logic [12:0] VEC [NVEC] = '{
        {1'b0, 2'b11, 1'b0, 1'b0, 4'b1011, 4'b1011}, // R6 load
        {1'b0, 2'b00, 1'b1, 1'b1, 4'b0110, 4'b1011}, // R3 hold
        {1'b0, 2'b10, 1'b0, 1'b1, 4'b0000, 4'b0101}, // R4 shr in 0
        {1'b0, 2'b10, 1'b1, 1'b0, 4'b0000, 4'b1010}, // R4 shr in 1
        {1'b0, 2'b01, 1'b0, 1'b1, 4'b1111, 4'b0101}, // R5 shl in 1
        {1'b0, 2'b01, 1'b1, 1'b0, 4'b0000, 4'b1010}, // R5 shl in 0
        {1'b1, 2'b11, 1'b1, 1'b1, 4'b1111, 4'b0000}, // R2 clear over load
        {1'b0, 2'b11, 1'b0, 1'b0, 4'b1111, 4'b1111}, // R6 load
        {1'b1, 2'b10, 1'b1, 1'b1, 4'b0000, 4'b0000}, // R2 clear over shr
        {1'b0, 2'b01, 1'b0, 1'b1, 4'b0000, 4'b0001}, // R5 shl
        {1'b0, 2'b01, 1'b0, 1'b1, 4'b0000, 4'b0011}, // R5 shl
        {1'b0, 2'b10, 1'b0, 1'b1, 4'b1000, 4'b0001}, // R4 shr
        {1'b0, 2'b11, 1'b1, 1'b1, 4'b0110, 4'b0110}, // R6 load
        {1'b1, 2'b00, 1'b0, 1'b0, 4'b1001, 4'b0000}  // R2 clear over hold
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive on the falling edge, pass one rising edge, sample 1 ns later.
    task automatic step(input logic c, input logic [1:0] m, input logic sl,
                        input logic sr, input logic [3:0] p);
        @(negedge clk);
        clr = c; mode = m; ser_from_left = sl; ser_from_right = sr; par_in = p;
        @(posedge clk);
        #1;
    endtask

    initial begin
        logic [3:0] word;
        logic [3:0] got;

        rst_n = 1'b0;
        mode = 2'b11; par_in = 4'b1111;
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset state", par_out, 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < NVEC; k++) begin
            step(VEC[k][12], VEC[k][11:10], VEC[k][9], VEC[k][8], VEC[k][7:4]);
            check($sformatf("R2-6 vec %0d", k), par_out, VEC[k][3:0]);
            check($sformatf("R7 ends vec %0d", k),
                  {2'b00, ser_out_left, ser_out_right},
                  {2'b00, VEC[k][3], VEC[k][0]});
        end

        // R1: reset wins over a pending load and clear low.
        step(1'b0, 2'b11, 1'b0, 1'b0, 4'b1111);
        @(negedge clk);
        rst_n = 1'b0; par_in = 4'b0101; mode = 2'b11;
        @(posedge clk);
        #1;
        check("R1 reset over load", par_out, 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: inputs stirred between edges leave the value in place.
        step(1'b0, 2'b11, 1'b0, 1'b0, 4'b1001);
        step(1'b0, 2'b00, 1'b0, 1'b0, 4'b1001);
        #1;
        par_in = 4'b0110; ser_from_left = 1'b1; ser_from_right = 1'b1;
        @(negedge clk);
        #3;
        check("R3 between edges", par_out, 4'b1001);
        @(posedge clk);
        #1;
        check("R3 hold edge", par_out, 4'b1001);

        // R8: right serialisation, LSB first on ser_out_right.
        word = 4'b1101;
        step(1'b0, 2'b11, 1'b0, 1'b0, word);
        got = 4'b0000;
        for (int b = 0; b < 4; b++) begin
            got[b] = ser_out_right;
            step(1'b0, 2'b10, 1'b0, 1'b0, 4'b0000);
        end
        check("R8 right stream", got, word);
        check("R8 drained right", par_out, 4'b0000);

        // R8: left serialisation, MSB first on ser_out_left.
        word = 4'b1011;
        step(1'b0, 2'b11, 1'b0, 1'b0, word);
        got = 4'b0000;
        for (int b = 3; b >= 0; b--) begin
            got[b] = ser_out_left;
            step(1'b0, 2'b01, 1'b0, 1'b0, 4'b0000);
        end
        check("R8 left stream", got, word);
        check("R8 drained left", par_out, 4'b0000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule